// File: doc/BRIEF.md
# Shared-Stripe Access Trigger Controller

This block sits in the memory stage of a pipeline and decides, for each load or store, whether the access must be diverted to a software handler before it executes. Diversion happens only inside a marked code region, only for pages flagged as shared, and only for the first load or the first store to a given stripe in that region. A stripe is an aligned block of 2^STRIPE_SHIFT bytes. The block learns whether a stripe was already touched from an external stripe record, which it supplies with insert requests. It also tells an external fetch-stage predictor how to update its entries.

When it fires, the block aborts the access and redirects fetch to a handler base held in a writable register. It captures the access address and the instruction PC for the handler to read. If the predictor did not foresee the diversion, it also asks for a pipeline flush. A predicted diversion still redirects in the same cycle but does not flush. Region start and end opcodes switch triggering on and off. A region start clears the stripe record and re-arms the predictor. A context switch flushes both tables.

Top module: `tac_trigger_top`

## Requirements
- R1: After reset, triggering is disabled, both capture registers read 0, and the handler base register reads RESET_BASE.
- R2: A region-start pulse enables triggering from the next cycle. A region-end pulse disables it from the next cycle. If both pulse in the same cycle, triggering ends up disabled. A context switch leaves the enable unchanged.
- R3: `trigger` is high exactly when `memValid`, the region is enabled, `pageShared` is 1, and `stripeHit` is 0. It is combinational within the same cycle.
- R4: `flushReq` is high exactly when `trigger` is high and `predHit` is 0. A predicted trigger never flushes.
- R5: `accessAbort` and `redirectValid` equal `trigger`, and `redirectPc` always shows the current handler base register. A base write takes effect from the next cycle.
- R6: After a trigger cycle, the address capture register holds that cycle's `memAddr` and the PC capture register holds `instPc`. Without a trigger, both keep their values. `regSel` selects the read: 0 is the handler base (also the write target when `regWe` is set), 1 is the address capture, 2 is the PC capture, and 3 reads 0. Reads are combinational.
- R7: `stripeInsValid` equals `trigger`. `stripeInsTag` is `memAddr` shifted right by STRIPE_SHIFT. `stripeInsStore` is 1 for a store and 0 for a load.
- R8: `predUpdValid` equals `trigger`. `predUpdPc` carries `instPc` and `predUpdHit` carries `predHit`. `predDrop` is high when a valid access inside an enabled region was predicted (`predHit` 1) but does not trigger.
- R9: `stripeClear` is high in any cycle with a region start or a context switch. `predFlush` is high exactly with a context switch. `predRearm` is high exactly with a region start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| segStart | input | 1 | Region-start opcode pulse |
| segEnd | input | 1 | Region-end opcode pulse |
| ctxSwitch | input | 1 | Context switch pulse |
| memValid | input | 1 | A load or store is in the memory stage |
| memIsStore | input | 1 | 1 = store, 0 = load |
| memAddr | input | XLEN | Access address |
| instPc | input | XLEN | PC of the access instruction |
| pageShared | input | 1 | Shared bit of the translated page (1 = shared) |
| stripeHit | input | 1 | Stripe record already holds (stripe, type) |
| predHit | input | 1 | Fetch-stage prediction that this access triggers |
| regWe | input | 1 | Register write strobe |
| regSel | input | 2 | Register select |
| regWdata | input | XLEN | Register write data |
| regRdata | output | XLEN | Register read data |
| trigger | output | 1 | Access diverts to the handler |
| accessAbort | output | 1 | Cancel the current load or store |
| flushReq | output | 1 | Pipeline flush request (unpredicted trigger) |
| redirectValid | output | 1 | Fetch redirect request |
| redirectPc | output | XLEN | Redirect target (handler base) |
| stripeInsValid | output | 1 | Insert request to the stripe record |
| stripeInsTag | output | XLEN-STRIPE_SHIFT | Stripe address to insert |
| stripeInsStore | output | 1 | Access type to insert |
| stripeClear | output | 1 | Empty the stripe record |
| predUpdValid | output | 1 | Predictor update request |
| predUpdPc | output | XLEN | PC of the predictor entry to update |
| predUpdHit | output | 1 | Whether the update follows a correct prediction |
| predDrop | output | 1 | Remove the predictor entry for `instPc` |
| predFlush | output | 1 | Empty the predictor |
| predRearm | output | 1 | Reset predictor invoked states for a new region |

## Verification
The bench builds the block with XLEN 32, STRIPE_SHIFT 4 and a non-zero RESET_BASE. With 16-byte stripes, addresses a few bytes apart fall into the same or neighbouring stripes. This exercises the stripe boundary (offsets 15 and 16) and the separate load and store entries of one stripe. A behavioural stripe set in the bench feeds `stripeHit`, so first-touch behaviour, clearing on region start and context switch, and the start/end collision are all reached across directed and random traffic.

// File: rtl/tac_pkg.sv
package tac_pkg;

  // register select encodings
  localparam logic [1:0] SEL_BASE = 2'd0;
  localparam logic [1:0] SEL_ADDR = 2'd1;
  localparam logic [1:0] SEL_PC   = 2'd2;

  // strobes from control to datapath
  typedef struct packed {
    logic capEn;
    logic baseWe;
  } tacStrobe_t;

endpackage

// File: rtl/tac_ctrl.sv
module tac_ctrl
  import tac_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       segStart,
  input  logic       segEnd,
  input  logic       ctxSwitch,
  input  logic       memValid,
  input  logic       pageShared,
  input  logic       stripeHit,
  input  logic       predHit,
  input  logic       regWe,
  input  logic [1:0] regSel,
  output tacStrobe_t strobe,
  output logic       trigger,
  output logic       flushReq,
  output logic       predDrop,
  output logic       stripeClear,
  output logic       predFlush,
  output logic       predRearm,
  output logic       regionActive
);

  logic activeQ;
  logic fire;
  logic armedAccess;

  // region enable: end dominates start
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      activeQ <= 1'b0;
    end else if (segEnd) begin
      activeQ <= 1'b0;
    end else if (segStart) begin
      activeQ <= 1'b1;
    end
  end

  assign regionActive = activeQ;
  assign armedAccess  = memValid & activeQ;

  always_comb begin
    fire        = armedAccess & pageShared & ~stripeHit;
    trigger     = fire;
    flushReq    = fire & ~predHit;
    predDrop    = armedAccess & predHit & ~fire;
    stripeClear = segStart | ctxSwitch;
    predFlush   = ctxSwitch;
    predRearm   = segStart;
  end

  always_comb begin
    strobe        = '0;
    strobe.capEn  = fire;
    strobe.baseWe = regWe & (regSel == SEL_BASE);
  end

endmodule

// File: rtl/tac_dpath.sv
module tac_dpath
  import tac_pkg::*;
#(
  parameter int          XLEN         = 32,
  parameter int          STRIPE_SHIFT = 6,
  parameter logic [XLEN-1:0] RESET_BASE = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  tacStrobe_t               strobe,
  input  logic [XLEN-1:0]          memAddr,
  input  logic [XLEN-1:0]          instPc,
  input  logic [1:0]               regSel,
  input  logic [XLEN-1:0]          regWdata,
  output logic [XLEN-1:0]          handlerBase,
  output logic [XLEN-1:0]          capAddr,
  output logic [XLEN-1:0]          capPc,
  output logic [XLEN-STRIPE_SHIFT-1:0] stripeTag,
  output logic [XLEN-1:0]          regRdata
);

  localparam int TAG_W = XLEN - STRIPE_SHIFT;

  logic [XLEN-1:0] baseQ;
  logic [XLEN-1:0] capAddrQ;
  logic [XLEN-1:0] capPcQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      baseQ <= RESET_BASE;
    end else if (strobe.baseWe) begin
      baseQ <= regWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      capAddrQ <= '0;
      capPcQ   <= '0;
    end else if (strobe.capEn) begin
      capAddrQ <= memAddr;
      capPcQ   <= instPc;
    end
  end

  assign stripeTag   = TAG_W'(memAddr >> STRIPE_SHIFT);
  assign handlerBase = baseQ;
  assign capAddr     = capAddrQ;
  assign capPc       = capPcQ;

  always_comb begin
    unique case (regSel)
      SEL_BASE: regRdata = baseQ;
      SEL_ADDR: regRdata = capAddrQ;
      SEL_PC:   regRdata = capPcQ;
      default:  regRdata = '0;
    endcase
  end

endmodule

// File: rtl/tac_trigger_top.sv
module tac_trigger_top
  import tac_pkg::*;
#(
  parameter int          XLEN         = 32,
  parameter int          STRIPE_SHIFT = 6,
  parameter logic [XLEN-1:0] RESET_BASE = 32'h0000_0400
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         segStart,
  input  logic                         segEnd,
  input  logic                         ctxSwitch,
  input  logic                         memValid,
  input  logic                         memIsStore,
  input  logic [XLEN-1:0]              memAddr,
  input  logic [XLEN-1:0]              instPc,
  input  logic                         pageShared,
  input  logic                         stripeHit,
  input  logic                         predHit,
  input  logic                         regWe,
  input  logic [1:0]                   regSel,
  input  logic [XLEN-1:0]              regWdata,
  output logic [XLEN-1:0]              regRdata,
  output logic                         trigger,
  output logic                         accessAbort,
  output logic                         flushReq,
  output logic                         redirectValid,
  output logic [XLEN-1:0]              redirectPc,
  output logic                         stripeInsValid,
  output logic [XLEN-STRIPE_SHIFT-1:0] stripeInsTag,
  output logic                         stripeInsStore,
  output logic                         stripeClear,
  output logic                         predUpdValid,
  output logic [XLEN-1:0]              predUpdPc,
  output logic                         predUpdHit,
  output logic                         predDrop,
  output logic                         predFlush,
  output logic                         predRearm
);

  tacStrobe_t                 strobe;
  logic                       fire;
  logic                       regionActive;
  logic [XLEN-1:0]            handlerBase;
  logic [XLEN-1:0]            capAddrQ;
  logic [XLEN-1:0]            capPcQ;
  logic [XLEN-STRIPE_SHIFT-1:0] tag;

  tac_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .segStart    (segStart),
    .segEnd      (segEnd),
    .ctxSwitch   (ctxSwitch),
    .memValid    (memValid),
    .pageShared  (pageShared),
    .stripeHit   (stripeHit),
    .predHit     (predHit),
    .regWe       (regWe),
    .regSel      (regSel),
    .strobe      (strobe),
    .trigger     (fire),
    .flushReq    (flushReq),
    .predDrop    (predDrop),
    .stripeClear (stripeClear),
    .predFlush   (predFlush),
    .predRearm   (predRearm),
    .regionActive(regionActive)
  );

  tac_dpath #(
    .XLEN        (XLEN),
    .STRIPE_SHIFT(STRIPE_SHIFT),
    .RESET_BASE  (RESET_BASE)
  ) u_dpath (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .memAddr    (memAddr),
    .instPc     (instPc),
    .regSel     (regSel),
    .regWdata   (regWdata),
    .handlerBase(handlerBase),
    .capAddr    (capAddrQ),
    .capPc      (capPcQ),
    .stripeTag  (tag),
    .regRdata   (regRdata)
  );

  assign trigger        = fire;
  assign accessAbort    = fire;
  assign redirectValid  = fire;
  assign redirectPc     = handlerBase;
  assign stripeInsValid = fire;
  assign stripeInsTag   = tag;
  assign stripeInsStore = memIsStore;
  assign predUpdValid   = fire;
  assign predUpdPc      = instPc;
  assign predUpdHit     = predHit;

endmodule

// File: rtl/tac_trigger_chk.sv
module tac_trigger_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            segEnd,
  input logic            ctxSwitch,
  input logic            memValid,
  input logic [XLEN-1:0] memAddr,
  input logic [XLEN-1:0] instPc,
  input logic            pageShared,
  input logic            stripeHit,
  input logic            predHit,
  input logic            trigger,
  input logic            flushReq,
  input logic            predDrop,
  input logic            stripeClear,
  input logic            predFlush,
  input logic            regionActive,
  input logic [XLEN-1:0] capAddrQ,
  input logic [XLEN-1:0] capPcQ
);

  // R2
  end_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    segEnd |=> !regionActive);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !regionActive |-> !trigger);

  // R3
  fire_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trigger |-> (memValid && pageShared && !stripeHit));

  // R4
  flush_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flushReq |-> (trigger && !predHit));

  // R6
  cap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trigger |=> (capAddrQ == $past(memAddr) && capPcQ == $past(instPc)));

  // R6
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trigger |=> ($stable(capAddrQ) && $stable(capPcQ)));

  // R8
  drop_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    predDrop |-> (predHit && !trigger && memValid));

  // R9
  ctx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctxSwitch |-> (stripeClear && predFlush));

endmodule

bind tac_trigger_top tac_trigger_chk #(.XLEN(XLEN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .segEnd      (segEnd),
  .ctxSwitch   (ctxSwitch),
  .memValid    (memValid),
  .memAddr     (memAddr),
  .instPc      (instPc),
  .pageShared  (pageShared),
  .stripeHit   (stripeHit),
  .predHit     (predHit),
  .trigger     (trigger),
  .flushReq    (flushReq),
  .predDrop    (predDrop),
  .stripeClear (stripeClear),
  .predFlush   (predFlush),
  .regionActive(regionActive),
  .capAddrQ    (capAddrQ),
  .capPcQ      (capPcQ)
);

// File: tb/tac_trigger_top_tb.sv
`timescale 1ns/1ps
module tac_trigger_top_tb;

  localparam int          XLEN  = 32;
  localparam int          SHIFT = 4;
  localparam logic [31:0] RBASE = 32'h0000_2000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic segStart = 0, segEnd = 0, ctxSwitch = 0;
  logic memValid = 0, memIsStore = 0, pageShared = 0, stripeHit = 0, predHit = 0;
  logic [31:0] memAddr = '0, instPc = '0, regWdata = '0;
  logic regWe = 0;
  logic [1:0] regSel = 2'd0;

  logic [31:0] regRdata, redirectPc, predUpdPc;
  logic [XLEN-SHIFT-1:0] stripeInsTag;
  logic trigger, accessAbort, flushReq, redirectValid, stripeInsValid, stripeInsStore;
  logic stripeClear, predUpdValid, predUpdHit, predDrop, predFlush, predRearm;

  always #4 clk = ~clk;

  tac_trigger_top #(.XLEN(XLEN), .STRIPE_SHIFT(SHIFT), .RESET_BASE(RBASE)) u_dut (
    .clk(clk), .rst_n(rst_n), .segStart(segStart), .segEnd(segEnd), .ctxSwitch(ctxSwitch),
    .memValid(memValid), .memIsStore(memIsStore), .memAddr(memAddr), .instPc(instPc),
    .pageShared(pageShared), .stripeHit(stripeHit), .predHit(predHit),
    .regWe(regWe), .regSel(regSel), .regWdata(regWdata), .regRdata(regRdata),
    .trigger(trigger), .accessAbort(accessAbort), .flushReq(flushReq),
    .redirectValid(redirectValid), .redirectPc(redirectPc),
    .stripeInsValid(stripeInsValid), .stripeInsTag(stripeInsTag), .stripeInsStore(stripeInsStore),
    .stripeClear(stripeClear), .predUpdValid(predUpdValid), .predUpdPc(predUpdPc),
    .predUpdHit(predUpdHit), .predDrop(predDrop), .predFlush(predFlush), .predRearm(predRearm)
  );

  int checks = 0;
  int fails  = 0;
  int trigCount = 0;
  bit done = 0;

  // behavioural reference state
  bit          mActive = 0;
  logic [31:0] mBase = RBASE, mCapA = '0, mCapP = '0;
  bit          seen [longint];

  function automatic longint keyOf(logic [31:0] a, logic st);
    return (longint'(a >> SHIFT) << 1) | longint'(st);
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference state update at the edge
  always @(posedge clk) begin
    if (!rst_n) begin
      mActive = 0; mBase = RBASE; mCapA = '0; mCapP = '0; seen.delete();
    end else begin
      if (memValid && mActive && pageShared && !stripeHit) begin
        mCapA = memAddr; mCapP = instPc; seen[keyOf(memAddr, memIsStore)] = 1'b1;
      end
      if (regWe && regSel == 2'd0) mBase = regWdata;
      if (segStart || ctxSwitch) seen.delete();
      if (segEnd) mActive = 0;
      else if (segStart) mActive = 1;
    end
  end

  // compare every cycle, away from the edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit eT;
      logic [31:0] eRd;
      eT = memValid && mActive && pageShared && !stripeHit;
      if (eT) trigCount++;
      chk(trigger == eT, "R3 trigger", trigger, eT);
      chk(flushReq == (eT && !predHit), "R4 flushReq", flushReq, eT && !predHit);
      chk(accessAbort == eT && redirectValid == eT, "R5 abort/redirect",
          {accessAbort, redirectValid}, {eT, eT});
      chk(redirectPc == mBase, "R5 redirectPc", redirectPc, mBase);
      case (regSel)
        2'd0: eRd = mBase;
        2'd1: eRd = mCapA;
        2'd2: eRd = mCapP;
        default: eRd = '0;
      endcase
      chk(regRdata == eRd, "R6 regRdata", regRdata, eRd);
      chk(stripeInsValid == eT, "R7 stripeInsValid", stripeInsValid, eT);
      if (eT) begin
        chk(stripeInsTag == (memAddr >> SHIFT), "R7 stripeInsTag", stripeInsTag, memAddr >> SHIFT);
        chk(stripeInsStore == memIsStore, "R7 stripeInsStore", stripeInsStore, memIsStore);
        chk(predUpdPc == instPc && predUpdHit == predHit, "R8 predUpd fields",
            {predUpdPc, predUpdHit}, {instPc, predHit});
      end
      chk(predUpdValid == eT, "R8 predUpdValid", predUpdValid, eT);
      chk(predDrop == (memValid && mActive && predHit && !eT), "R8 predDrop",
          predDrop, memValid && mActive && predHit && !eT);
      chk(stripeClear == (segStart || ctxSwitch) && predFlush == ctxSwitch
          && predRearm == segStart, "R9 table clears",
          {stripeClear, predFlush, predRearm}, {segStart || ctxSwitch, ctxSwitch, segStart});
    end
  end

  task automatic idle();
    memValid = 0; segStart = 0; segEnd = 0; ctxSwitch = 0; regWe = 0; predHit = 0;
  endtask

  task automatic step();
    @(posedge clk); #1;
    idle();
  endtask

  // drive one access for the coming cycle; stripe hit comes from the reference set
  task automatic acc(logic st, logic [31:0] a, logic [31:0] pc, logic sh, logic pr);
    memValid = 1; memIsStore = st; memAddr = a; instPc = pc; pageShared = sh; predHit = pr;
    stripeHit = seen.exists(keyOf(a, st));
  endtask

  task automatic waitHalf();
    @(negedge clk); #1;
  endtask

  initial begin
    idle();
    repeat (3) @(posedge clk);
    #1;
    // R1 reset values, read while reset is held
    regSel = 2'd0; #1;
    chk(regRdata == RBASE, "R1 base after reset", regRdata, RBASE);
    regSel = 2'd1; #1;
    chk(regRdata == 0, "R1 capAddr after reset", regRdata, 0);
    regSel = 2'd2; #1;
    chk(regRdata == 0, "R1 capPc after reset", regRdata, 0);
    chk(trigger == 0 && flushReq == 0, "R1 quiet outputs", {trigger, flushReq}, 0);
    @(posedge clk); #1; rst_n = 1;
    regSel = 2'd1;

    // R2 no trigger outside a region
    acc(0, 32'h8000, 32'h100, 1, 0); waitHalf();
    chk(trigger == 0, "R2 inactive region", trigger, 0);
    step();

    segStart = 1; step();
    // R3 first load to shared stripe triggers, unpredicted -> flush (R4)
    acc(0, 32'h8004, 32'h104, 1, 0); waitHalf();
    chk(trigger == 1 && flushReq == 1, "R4 unpredicted first load", {trigger, flushReq}, 2'b11);
    step();
    // R6 capture visible next cycle
    regSel = 2'd1; #1;
    chk(regRdata == 32'h8004, "R6 captured address", regRdata, 32'h8004);
    regSel = 2'd2; #1;
    chk(regRdata == 32'h104, "R6 captured PC", regRdata, 32'h104);
    // same stripe, same type: no trigger
    acc(0, 32'h800F, 32'h108, 1, 1); waitHalf();
    chk(trigger == 0 && predDrop == 1, "R8 repeat load drops prediction", {trigger, predDrop}, 2'b01);
    step();
    // store to same stripe: predicted trigger, no flush
    acc(1, 32'h8000, 32'h10C, 1, 1); waitHalf();
    chk(trigger == 1 && flushReq == 0, "R4 predicted store no flush", {trigger, flushReq}, 2'b10);
    step();
    // next stripe boundary
    acc(0, 32'h8010, 32'h110, 1, 0); waitHalf();
    chk(trigger == 1, "R3 stripe boundary", trigger, 1);
    step();
    // non-shared page
    acc(0, 32'h9000, 32'h114, 0, 0); waitHalf();
    chk(trigger == 0, "R3 non-shared page", trigger, 0);
    step();
    // R5 base write then redirect
    regWe = 1; regSel = 2'd0; regWdata = 32'h0000_3F00; step();
    regSel = 2'd0;
    acc(1, 32'h8020, 32'h118, 1, 0); waitHalf();
    chk(redirectPc == 32'h3F00 && redirectValid, "R5 new handler base", redirectPc, 32'h3F00);
    step();
    // R9 context switch clears the stripe record; access repeats trigger
    ctxSwitch = 1; step();
    acc(0, 32'h8004, 32'h11C, 1, 0); waitHalf();
    chk(trigger == 1, "R9 trigger after context switch", trigger, 1);
    step();
    // R2 start and end together: disabled
    segStart = 1; segEnd = 1; step();
    acc(0, 32'h8040, 32'h120, 1, 0); waitHalf();
    chk(trigger == 0, "R2 start+end leaves region closed", trigger, 0);
    step();

    // random traffic
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] a;
      a = 32'h8000 + (($urandom % 8) << 4) + ($urandom % 16);
      if (($urandom % 16) == 0) segStart = 1;
      if (($urandom % 29) == 0) segEnd = 1;
      if (($urandom % 41) == 0) ctxSwitch = 1;
      if (($urandom % 23) == 0) begin regWe = 1; regWdata = $urandom; end
      regSel = 2'($urandom % 4);
      if (($urandom % 4) != 0) acc(1'($urandom % 2), a, $urandom, ~a[6], 1'($urandom % 2));
      step();
    end
    chk(trigCount > 20, "R3 random traffic reached triggers", trigCount, 20);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 200000) begin
      @(posedge clk); cyc++;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    #2;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule